// File: doc/BRIEF.md
# Streaming Population Count Accumulator

This block sums the number of set bits over an entire stream of data words. Words arrive on an AXI4-Stream slave port, normally pushed by a DMA engine out of a memory buffer. Each accepted word is reduced to its count of ones, and that count is added to a running total. A processor reaches the block through a small AXI4-Lite slave. It can read the total and the number of words taken in, and it can clear both through a control register, for example before starting the next buffer.

The per-word count is built from 8-bit slices. Each slice goes through a lookup table that gives a 4-bit result from 0 to 8. A build-time parameter `MODE` then picks how the slice results are combined. `CNT_TABLE_ADD` sums them in an adder chain. `CNT_TABLE_TREE`, the default, pairs them through a second table layer and then does one final add. `CNT_SHIFT_MASK` skips the slice tables and folds the word with parallel shift, mask and add levels, with no multiplier. The count of one word is registered for one cycle before it reaches the accumulator.

Both register channels are small state machines.

The write side starts in `WR_IDLE`. When address and data are valid together, it takes both, performs the register write, and moves to `WR_RESP`. It leaves `WR_RESP` for `WR_IDLE` once the response is taken (`bready`).

The read side starts in `RD_IDLE`. On a valid address it captures the register value and moves to `RD_DATA`. It returns to `RD_IDLE` once `rready` takes the data.

Top module: `popcnt_stream_acc`

## Requirements
- R1: After reset the total and word count are 0, and `s_tready` is high.
- R2: Each stream word accepted (`s_tvalid` and `s_tready` both high at a clock edge) adds its number of set bits (0 to 32) to the 32-bit total at offset 0x0. Cycles without acceptance leave the total unchanged.
- R3: Offset 0x8 returns the number of words accepted since the last clear or reset.
- R4: A read returns the total as of two cycles before its address handshake. A word accepted at edge e appears in reads whose address handshake is at edge e+2 or later, and not in reads at edge e or e+1.
- R5: A write to offset 0x4 with `wdata[0]`=1 and `wstrb[0]`=1 zeroes the total and word count at its handshake edge. A write there with `wdata[0]`=0 or `wstrb[0]`=0 changes nothing.
- R6: `s_tready` is low in exactly the cycle in which a clearing write handshakes, and high in every other cycle after reset.
- R7: A word accepted at the edge just before a clear edge, still held in the count stage, is discarded and is not added to the total or the word count.
- R8: Reads of offset 0x4 or any unmapped offset return 0. Writes to any offset other than 0x4 change nothing.
- R9: Every address handshake produces exactly one response with code OKAY (00). `bvalid` and `rvalid` hold, and `rdata` holds steady, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Stream ready, low only during a clear |
| s_tdata | input | 32 | Stream word |
| csr_awaddr | input | 4 | Write address |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address ready |
| csr_wdata | input | 32 | Write data |
| csr_wstrb | input | 4 | Write byte strobes |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data ready |
| csr_bresp | output | 2 | Write response code |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response ready |
| csr_araddr | input | 4 | Read address |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address ready |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response code |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data ready |

## Verification
The functions that can collide in one cycle are a clearing register write and stream acceptance. The collision comes in two forms.

In the first, the bench raises `s_tvalid` in the very cycle the clear handshakes. That word must be refused and then taken on the following edge, so it counts after the clear.

In the second, the bench pushes a word one edge before the clear. That word is caught in the count stage and must vanish.

The behavioural reference model follows the acceptance and clear rules and the two-cycle read window independently of the RTL. It judges `s_tready` and every read value on each clock, while random streaming runs alongside random reads.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    typedef enum logic [1:0] {
        CNT_TABLE_ADD  = 2'd0,
        CNT_TABLE_TREE = 2'd1,
        CNT_SHIFT_MASK = 2'd2
    } cnt_mode_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_RESP = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_DATA = 1'b1
    } rd_state_e;

    localparam int OFF_TOTAL = 'h0;
    localparam int OFF_CTRL  = 'h4;
    localparam int OFF_WORDS = 'h8;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/popcnt_word.sv
module popcnt_word
    import popcnt_pkg::*;
#(
    parameter int        DATA_W  = 32,
    parameter int        SLICE_W = 8,
    parameter cnt_mode_e MODE    = CNT_TABLE_TREE,
    localparam int       CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word,
    output logic [CNT_W-1:0]  ones
);

    localparam int N_SLICE  = DATA_W / SLICE_W;
    localparam int SL_CNT_W = $clog2(SLICE_W + 1);
    localparam int N_PAIR   = N_SLICE / 2;
    localparam int PAIR_W   = $clog2(2 * SLICE_W + 1);
    localparam int LEVELS   = $clog2(DATA_W);

    function automatic logic [SL_CNT_W-1:0] slice_ones(input logic [SLICE_W-1:0] v);
        logic [SL_CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < SLICE_W; i++) n = n + SL_CNT_W'(v[i]);
        return n;
    endfunction

    function automatic logic [PAIR_W-1:0] pair_table(input logic [2*SL_CNT_W-1:0] v);
        return PAIR_W'(v[SL_CNT_W-1:0]) + PAIR_W'(v[2*SL_CNT_W-1:SL_CNT_W]);
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input int span);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = ((i % (2 * span)) < span);
        return m;
    endfunction

    generate
        if (MODE == CNT_SHIFT_MASK) begin : g_fold
            logic [DATA_W-1:0] lvl [LEVELS+1];
            logic              unused_fold;
            assign lvl[0] = word;
            for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
                localparam int SPAN = 1 << l;
                localparam logic [DATA_W-1:0] MASK = lane_mask(SPAN);
                assign lvl[l+1] = (lvl[l] & MASK) + ((lvl[l] >> SPAN) & MASK);
            end
            assign ones        = lvl[LEVELS][CNT_W-1:0];
            assign unused_fold = ^lvl[LEVELS][DATA_W-1:CNT_W];
        end else begin : g_tables
            logic [SL_CNT_W-1:0] slice_cnt [N_SLICE];
            for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
                assign slice_cnt[g] = slice_ones(word[g*SLICE_W +: SLICE_W]);
            end
            if (MODE == CNT_TABLE_TREE) begin : g_tree
                logic [PAIR_W-1:0] pair_cnt [N_PAIR];
                for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
                    assign pair_cnt[p] = pair_table({slice_cnt[2*p+1], slice_cnt[2*p]});
                end
                always_comb begin
                    ones = '0;
                    for (int p = 0; p < N_PAIR; p++) ones = ones + CNT_W'(pair_cnt[p]);
                end
            end else begin : g_adders
                always_comb begin
                    ones = '0;
                    for (int g = 0; g < N_SLICE; g++) ones = ones + CNT_W'(slice_cnt[g]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/popcnt_accum.sv
module popcnt_accum #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] in_cnt,
    input  logic             clear,
    output logic             stage_valid,
    output logic [CNT_W-1:0] stage_cnt,
    output logic [ACC_W-1:0] total,
    output logic [ACC_W-1:0] words
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_valid <= 1'b0;
            stage_cnt   <= '0;
            total       <= '0;
            words       <= '0;
        end else if (clear) begin
            stage_valid <= 1'b0;
            stage_cnt   <= '0;
            total       <= '0;
            words       <= '0;
        end else begin
            stage_valid <= in_valid;
            stage_cnt   <= in_cnt;
            if (stage_valid) begin
                total <= total + ACC_W'(stage_cnt);
                words <= words + 1'b1;
            end
        end
    end

endmodule

// File: rtl/popcnt_lite_regs.sv
module popcnt_lite_regs
    import popcnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LITE_W = 32,
    parameter int ACC_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [LITE_W-1:0]   wdata,
    input  logic [LITE_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [LITE_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    input  logic [ACC_W-1:0]    total,
    input  logic [ACC_W-1:0]    words,
    output logic                clear
);

    wr_state_e           wr_q, wr_d;
    rd_state_e           rd_q, rd_d;
    logic [LITE_W-1:0]   read_mux;
    logic [LITE_W-1:0]   rdata_q;
    logic                unused_bits;

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= WR_IDLE;
            rd_q <= RD_IDLE;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    // Transitions
    always_comb begin
        wr_d = wr_q;
        unique case (wr_q)
            WR_IDLE: if (awvalid && wvalid) wr_d = WR_RESP;
            WR_RESP: if (bready)            wr_d = WR_IDLE;
        endcase
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: if (arvalid) rd_d = RD_DATA;
            RD_DATA: if (rready)  rd_d = RD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (wr_q)
            WR_IDLE: begin
                awready = awvalid && wvalid;
                wready  = awvalid && wvalid;
            end
            WR_RESP: bvalid = 1'b1;
        endcase
        unique case (rd_q)
            RD_IDLE: arready = 1'b1;
            RD_DATA: rvalid  = 1'b1;
        endcase
        bresp = RESP_OKAY;
        rresp = RESP_OKAY;
        clear = awready && (awaddr == ADDR_W'(OFF_CTRL)) && wdata[0] && wstrb[0];
        rdata = rdata_q;
    end

    always_comb begin
        if (araddr == ADDR_W'(OFF_TOTAL))      read_mux = LITE_W'(total);
        else if (araddr == ADDR_W'(OFF_WORDS)) read_mux = LITE_W'(words);
        else                                   read_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         rdata_q <= '0;
        else if (rd_q == RD_IDLE && arvalid) rdata_q <= read_mux;
    end

    assign unused_bits = ^{wdata[LITE_W-1:1], wstrb[LITE_W/8-1:1]};

endmodule

// File: rtl/popcnt_stream_acc.sv
module popcnt_stream_acc
    import popcnt_pkg::*;
#(
    parameter int        DATA_W  = 32,
    parameter int        SLICE_W = 8,
    parameter int        ACC_W   = 32,
    parameter int        ADDR_W  = 4,
    parameter int        LITE_W  = 32,
    parameter cnt_mode_e MODE    = CNT_TABLE_TREE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [ADDR_W-1:0]   csr_awaddr,
    input  logic                csr_awvalid,
    output logic                csr_awready,
    input  logic [LITE_W-1:0]   csr_wdata,
    input  logic [LITE_W/8-1:0] csr_wstrb,
    input  logic                csr_wvalid,
    output logic                csr_wready,
    output logic [1:0]          csr_bresp,
    output logic                csr_bvalid,
    input  logic                csr_bready,
    input  logic [ADDR_W-1:0]   csr_araddr,
    input  logic                csr_arvalid,
    output logic                csr_arready,
    output logic [LITE_W-1:0]   csr_rdata,
    output logic [1:0]          csr_rresp,
    output logic                csr_rvalid,
    input  logic                csr_rready
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic             clear;
    logic             accept;
    logic [CNT_W-1:0] word_ones;
    logic             stage_valid;
    logic [CNT_W-1:0] stage_cnt;
    logic [ACC_W-1:0] total_q;
    logic [ACC_W-1:0] words_q;

    assign s_tready = !clear;
    assign accept   = s_tvalid && s_tready;

    popcnt_word #(
        .DATA_W  (DATA_W),
        .SLICE_W (SLICE_W),
        .MODE    (MODE)
    ) u_word (
        .word (s_tdata),
        .ones (word_ones)
    );

    popcnt_accum #(
        .ACC_W (ACC_W),
        .CNT_W (CNT_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (accept),
        .in_cnt      (word_ones),
        .clear       (clear),
        .stage_valid (stage_valid),
        .stage_cnt   (stage_cnt),
        .total       (total_q),
        .words       (words_q)
    );

    popcnt_lite_regs #(
        .ADDR_W (ADDR_W),
        .LITE_W (LITE_W),
        .ACC_W  (ACC_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (csr_awaddr),
        .awvalid (csr_awvalid),
        .awready (csr_awready),
        .wdata   (csr_wdata),
        .wstrb   (csr_wstrb),
        .wvalid  (csr_wvalid),
        .wready  (csr_wready),
        .bresp   (csr_bresp),
        .bvalid  (csr_bvalid),
        .bready  (csr_bready),
        .araddr  (csr_araddr),
        .arvalid (csr_arvalid),
        .arready (csr_arready),
        .rdata   (csr_rdata),
        .rresp   (csr_rresp),
        .rvalid  (csr_rvalid),
        .rready  (csr_rready),
        .total   (total_q),
        .words   (words_q),
        .clear   (clear)
    );

endmodule

// File: rtl/popcnt_checker.sv
module popcnt_checker
    import popcnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 6,
    parameter int ADDR_W = 4,
    parameter int LITE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic [ADDR_W-1:0]   awaddr,
    input logic                awvalid,
    input logic                awready,
    input logic [LITE_W-1:0]   wdata,
    input logic [LITE_W/8-1:0] wstrb,
    input logic                wvalid,
    input logic                wready,
    input logic                bvalid,
    input logic                bready,
    input logic                rvalid,
    input logic                rready,
    input logic [LITE_W-1:0]   rdata,
    input logic                stage_valid,
    input logic [CNT_W-1:0]    stage_cnt,
    input logic [ACC_W-1:0]    total,
    input logic [ACC_W-1:0]    words
);

    logic clr_hs;
    assign clr_hs = awvalid && awready && wvalid && wready &&
                    (awaddr == ADDR_W'(OFF_CTRL)) && wdata[0] && wstrb[0];

    assert_tready_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hs |-> !s_tready);

    assert_tready_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hs |-> s_tready);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hs |=> (total == '0 && words == '0));

    assert_inflight_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hs |=> !stage_valid);

    assert_accept_staged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |=> stage_valid);

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid |-> (stage_cnt <= CNT_W'(DATA_W)));

    assert_total_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hs && stage_valid) |=> (total == $past(total) + ACC_W'($past(stage_cnt))));

    assert_total_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hs && !stage_valid) |=> ($stable(total) && $stable(words)));

    assert_words_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hs && stage_valid) |=> (words == $past(words) + 1'b1));

    assert_bvalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    assert_rvalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

bind popcnt_stream_acc popcnt_checker #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .LITE_W (LITE_W)
) u_popcnt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_tvalid    (s_tvalid),
    .s_tready    (s_tready),
    .awaddr      (csr_awaddr),
    .awvalid     (csr_awvalid),
    .awready     (csr_awready),
    .wdata       (csr_wdata),
    .wstrb       (csr_wstrb),
    .wvalid      (csr_wvalid),
    .wready      (csr_wready),
    .bvalid      (csr_bvalid),
    .bready      (csr_bready),
    .rvalid      (csr_rvalid),
    .rready      (csr_rready),
    .rdata       (csr_rdata),
    .stage_valid (stage_valid),
    .stage_cnt   (stage_cnt),
    .total       (total_q),
    .words       (words_q)
);

// File: tb/test_popcnt_stream_acc.sv
module test_popcnt_stream_acc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] s_tdata = '0;
    logic [3:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b1;
    logic [3:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    popcnt_stream_acc i_popcnt_stream_acc (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .csr_awaddr(awaddr), .csr_awvalid(awvalid), .csr_awready(awready),
        .csr_wdata(wdata), .csr_wstrb(wstrb), .csr_wvalid(wvalid), .csr_wready(wready),
        .csr_bresp(bresp), .csr_bvalid(bvalid), .csr_bready(bready),
        .csr_araddr(araddr), .csr_arvalid(arvalid), .csr_arready(arready),
        .csr_rdata(rdata), .csr_rresp(rresp), .csr_rvalid(rvalid), .csr_rready(rready)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_total, m_words, m_rdata, m_pc;
    logic [3:0]  m_raddr;
    bit          m_pv, m_wbusy, m_rbusy;

    function automatic bit clr_req();
        return !m_wbusy && awvalid && wvalid && awaddr == 4'h4 && wdata[0] && wstrb[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_total = 0; m_words = 0; m_pv = 0; m_pc = 0;
            m_wbusy = 0; m_rbusy = 0; m_rdata = 0; m_raddr = 0;
        end else begin
            bit clr;
            clr = clr_req();
            if (m_rbusy) begin
                if (rready) m_rbusy = 0;
            end else if (arvalid) begin
                m_rbusy = 1;
                m_raddr = araddr;
                m_rdata = (araddr == 4'h0) ? m_total : (araddr == 4'h8) ? m_words : 32'h0;
            end
            if (m_wbusy) begin
                if (bready) m_wbusy = 0;
            end else if (awvalid && wvalid) m_wbusy = 1;
            if (clr) begin
                m_total = 0; m_words = 0; m_pv = 0;
            end else begin
                if (m_pv) begin
                    m_total = m_total + m_pc;
                    m_words = m_words + 1;
                end
                m_pv = s_tvalid;
                m_pc = $countones(s_tdata);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 s_tready", {31'h0, s_tready}, {31'h0, !clr_req()});
            chk("R9 awready", {31'h0, awready}, {31'h0, !m_wbusy && awvalid && wvalid});
            chk("R9 bvalid", {31'h0, bvalid}, {31'h0, m_wbusy});
            chk("R9 arready", {31'h0, arready}, {31'h0, !m_rbusy});
            chk("R9 rvalid", {31'h0, rvalid}, {31'h0, m_rbusy});
            chk("R9 resp", {28'h0, bresp, rresp}, 32'h0);
            if (m_rbusy) begin
                if (m_raddr == 4'h0)      chk("R2 R4 total read", rdata, m_rdata);
                else if (m_raddr == 4'h8) chk("R3 words read", rdata, m_rdata);
                else                      chk("R8 other read", rdata, m_rdata);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input logic [31:0] w);
        s_tvalid = 1'b1;
        s_tdata  = w;
        #1;
        while (!s_tready) begin tick(); #1; end
        tick();
        s_tvalid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s, input int stall);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        bready = (stall == 0);
        #1;
        while (!awready) begin tick(); #1; end
        tick();
        awvalid = 1'b0; wvalid = 1'b0;
        repeat (stall) tick();
        bready = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [3:0] a, input int stall, output logic [31:0] v);
        araddr = a; arvalid = 1'b1;
        rready = (stall == 0);
        #1;
        while (!arready) begin tick(); #1; end
        tick();
        arvalid = 1'b0;
        v = rdata;
        repeat (stall) tick();
        rready = 1'b1;
        tick();
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, sum, base;
        logic [31:0] pat [6];
        pat[0] = 32'h0000_0000; pat[1] = 32'hFFFF_FFFF; pat[2] = 32'hA5A5_A5A5;
        pat[3] = 32'h0000_0001; pat[4] = 32'h8000_0000; pat[5] = 32'h0F0F_00FF;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 tready after reset", {31'h0, s_tready}, 32'h1);
        rd(4'h0, 0, v); chk("R1 total after reset", v, 0);
        rd(4'h8, 0, v); chk("R1 words after reset", v, 0);
        rd(4'h4, 0, v); chk("R8 ctrl reads zero", v, 0);

        sum = 0;
        foreach (pat[i]) begin
            push(pat[i]);
            sum += $countones(pat[i]);
        end
        tick(); tick();
        rd(4'h0, 0, v); chk("R2 total of patterns", v, sum);
        rd(4'h8, 0, v); chk("R3 word count", v, 6);
        rd(4'hC, 0, v); chk("R8 unmapped read", v, 0);

        wr(4'h0, 32'h1234_5678, 4'hF, 0);
        wr(4'h8, 32'h1, 4'hF, 0);
        rd(4'h0, 0, v); chk("R8 write elsewhere ignored", v, sum);
        wr(4'h4, 32'h0, 4'hF, 0);
        rd(4'h0, 0, v); chk("R5 ctrl write of 0 ignored", v, sum);
        wr(4'h4, 32'h1, 4'h0, 2);
        rd(4'h8, 0, v); chk("R5 strobe-off write ignored", v, 6);
        wr(4'h4, 32'h1, 4'hF, 3);
        rd(4'h0, 0, v); chk("R5 total cleared", v, 0);
        rd(4'h8, 2, v); chk("R5 words cleared", v, 0);

        // R4: word at edge e, read at e+1 excludes it, read at e+2 includes
        s_tvalid = 1'b1; s_tdata = 32'h0000_00FF;
        tick(); s_tvalid = 1'b0;
        rd(4'h0, 0, v); chk("R4 read one edge after word", v, 0);
        s_tvalid = 1'b1; s_tdata = 32'h0000_00FF;
        tick(); s_tvalid = 1'b0;
        tick();
        rd(4'h0, 0, v); chk("R4 read two edges after word", v, 16);

        // R7: two words, the second still staged when the clear lands
        s_tvalid = 1'b1; s_tdata = 32'hFFFF_0000;
        tick(); s_tdata = 32'h0000_FFFF;
        tick(); s_tvalid = 1'b0;
        awaddr = 4'h4; wdata = 32'h1; wstrb = 4'h1; awvalid = 1'b1; wvalid = 1'b1;
        tick(); awvalid = 1'b0; wvalid = 1'b0;
        tick(); tick();
        rd(4'h0, 0, v); chk("R7 staged word dropped (total)", v, 0);
        rd(4'h8, 0, v); chk("R7 staged word dropped (words)", v, 0);

        // R6: word offered in the clear cycle is refused, then taken afterwards
        s_tvalid = 1'b1; s_tdata = 32'h7000_0003;
        awaddr = 4'h4; wdata = 32'h1; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        chk("R6 tready low in clear cycle", {31'h0, s_tready}, 32'h0);
        tick(); awvalid = 1'b0; wvalid = 1'b0;
        #1;
        chk("R6 tready back high", {31'h0, s_tready}, 32'h1);
        tick(); s_tvalid = 1'b0;
        tick(); tick();
        rd(4'h0, 0, v); chk("R6 held word counted after clear", v, 5);
        rd(4'h8, 0, v); chk("R6 held word in word count", v, 1);

        // random streaming with concurrent reads
        base = 5; sum = 0;
        fork
            begin
                for (int k = 0; k < 400; k++) begin
                    s_tvalid = ($urandom % 3) != 0;
                    s_tdata  = $urandom;
                    if (s_tvalid) sum += $countones(s_tdata);
                    tick();
                end
                s_tvalid = 1'b0;
            end
            begin
                for (int k = 0; k < 30; k++) begin
                    logic [31:0] dummy;
                    rd(($urandom % 2) ? 4'h8 : 4'h0, $urandom % 3, dummy);
                end
            end
        join
        tick(); tick();
        rd(4'h0, 0, v); chk("R2 total after random stream", v, base + sum);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule